// File: doc/BRIEF.md
# Cartridge ROM/RAM Bank Controller

This block watches processor writes that land in the lower half of a 16-bit address space, the region where cartridge ROM is normally mapped. The ROM cannot be written, so those writes are treated as commands to a bank-switching controller. The block keeps the controller's state: a 7-bit ROM bank, a 2-bit RAM bank, an external-RAM enable and a banking mode bit. The upper half of the address space is ignored.

Four 8 KiB slices of the command window each drive one control field. The address bits just below the top bit select the slice. The active ROM bank never carries zero in its low five bits. A shared 2-bit field goes either to the top two ROM bank bits or to the RAM bank, depending on the mode bit. The block also presents byte offsets into ROM (16 KiB pages) and into external RAM (8 KiB pages). These offsets are registered and always agree with the bank outputs. Read-path muxing and the memories themselves live outside this block.

Top module: `cart_bank_ctrl`

## Requirements
- R1: Synchronous reset sets rom_bank to 1, ram_bank to 0, ram_enable to 0, mode to 0, rom_offset to 0x4000 and ram_offset to 0. Reset takes priority over a write in the same cycle.
- R2: A strobed write with wr_addr in 0x0000–0x1FFF sets ram_enable to 1 when wr_data[3:0] is 0xA, and clears it for any other low nibble. wr_data[7:4] has no effect.
- R3: A strobed write with wr_addr in 0x2000–0x3FFF loads wr_data[4:0] into rom_bank[4:0] and keeps rom_bank[6:5].
- R4: In the R3 write, when wr_data[4:0] is zero, rom_bank[4:0] becomes 1.
- R5: A strobed write with wr_addr in 0x6000–0x7FFF sets the mode bit to wr_data[0]. Mode 1 selects RAM banking and mode 0 selects upper-ROM banking. The write changes no output directly.
- R6: A strobed write with wr_addr in 0x4000–0x5FFF in mode 1 loads wr_data[1:0] into ram_bank and leaves rom_bank unchanged.
- R7: A strobed write with wr_addr in 0x4000–0x5FFF in mode 0 loads wr_data[1:0] into rom_bank[6:5], keeps rom_bank[4:0] and leaves ram_bank unchanged.
- R8: rom_offset equals rom_bank × 0x4000 and ram_offset equals ram_bank × 0x2000. Both offsets are registered and change on the same clock edge as the bank they follow.
- R9: A write with wr_addr at 0x8000 or above, or any cycle without wr_en, leaves all state and outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 16 | Write address |
| wr_data | input | 8 | Write data |
| rom_bank | output | 7 | Active ROM bank |
| ram_bank | output | 2 | Active external-RAM bank |
| ram_enable | output | 1 | External RAM access enable |
| rom_offset | output | 21 | ROM byte offset, rom_bank × 16 KiB |
| ram_offset | output | 15 | RAM byte offset, ram_bank × 8 KiB |

## Verification
Two functions can fall in the same cycle: a bank write and its offset update. When the shared 2-bit field is written in mode 0, both rom_bank and rom_offset must move on the same edge. The bench checks the offsets against bank × page size on every vector, in the cycle after each write. A second collision is a synchronous reset arriving together with a strobed RAM-enable write. The bench provokes it directly and expects the reset values with RAM still disabled.

// File: rtl/cbc_pkg.sv
package cbc_pkg;
  // Which control field a command-window write targets (address bits 14:13)
  typedef enum logic [1:0] {
    REG_RAMEN = 2'd0,
    REG_ROMLO = 2'd1,
    REG_UPPER = 2'd2,
    REG_MODE  = 2'd3
  } cbc_reg_e;
endpackage

// File: rtl/cbc_decode.sv
module cbc_decode
  import cbc_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output cbc_reg_e          sel
);
  localparam int SEL_LSB = ADDR_W - 3;

  logic unused_addr;
  assign unused_addr = ^addr[SEL_LSB-1:0];

  // Command window is the lower half of the address space
  assign hit = wr_en & ~addr[ADDR_W-1];
  assign sel = cbc_reg_e'(addr[ADDR_W-2:SEL_LSB]);
endmodule

// File: rtl/cbc_regs.sv
module cbc_regs
  import cbc_pkg::*;
#(
  parameter int          DATA_W     = 8,
  parameter int          ROM_BANK_W = 7,
  parameter int          RAM_BANK_W = 2,
  parameter int          LO_W       = 5,
  parameter logic [3:0]  RAM_KEY    = 4'hA
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  hit,
  input  cbc_reg_e              sel,
  input  logic [DATA_W-1:0]     data,
  output logic [ROM_BANK_W-1:0] rom_bank,
  output logic [RAM_BANK_W-1:0] ram_bank,
  output logic                  ram_en,
  output logic [ROM_BANK_W-1:0] rom_nxt,
  output logic [RAM_BANK_W-1:0] ram_nxt
);
  localparam int HI_W = ROM_BANK_W - LO_W;

  logic mode_q, mode_n, en_n;

  logic unused_data;
  assign unused_data = ^data[DATA_W-1:LO_W];

  always_comb begin
    rom_nxt = rom_bank;
    ram_nxt = ram_bank;
    en_n    = ram_en;
    mode_n  = mode_q;
    if (hit) begin
      unique case (sel)
        REG_RAMEN: en_n = (data[3:0] == RAM_KEY);
        REG_ROMLO: rom_nxt[LO_W-1:0] = (data[LO_W-1:0] == '0) ? LO_W'(1) : data[LO_W-1:0];
        REG_UPPER: begin
          if (mode_q) ram_nxt = data[RAM_BANK_W-1:0];
          else        rom_nxt[ROM_BANK_W-1:LO_W] = data[HI_W-1:0];
        end
        REG_MODE:  mode_n = data[0];
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_bank <= ROM_BANK_W'(1);
      ram_bank <= '0;
      ram_en   <= 1'b0;
      mode_q   <= 1'b0;
    end else begin
      rom_bank <= rom_nxt;
      ram_bank <= ram_nxt;
      ram_en   <= en_n;
      mode_q   <= mode_n;
    end
  end

  // R1: reset state
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (rom_bank == ROM_BANK_W'(1) && ram_bank == '0 && !ram_en && !mode_q));

  // R2: enable key
  p_ramen_key_r2: assert property (@(posedge clk) disable iff (rst)
    (hit && sel == REG_RAMEN) |=> (ram_en == ($past(data[3:0]) == RAM_KEY)));

  // R3: low field write keeps upper bits
  p_lo_keeps_hi_r3: assert property (@(posedge clk) disable iff (rst)
    (hit && sel == REG_ROMLO) |=> $stable(rom_bank[ROM_BANK_W-1:LO_W]));

  // R4: zero remapped to one
  p_zero_remap_r4: assert property (@(posedge clk) disable iff (rst)
    (hit && sel == REG_ROMLO && data[LO_W-1:0] == '0) |=> (rom_bank[LO_W-1:0] == LO_W'(1)));

  // R5: mode write
  p_mode_load_r5: assert property (@(posedge clk) disable iff (rst)
    (hit && sel == REG_MODE) |=> (mode_q == $past(data[0])));

  // R6: RAM banking mode leaves ROM bank alone
  p_upper_mode1_r6: assert property (@(posedge clk) disable iff (rst)
    (hit && sel == REG_UPPER && mode_q) |=>
      (ram_bank == $past(data[RAM_BANK_W-1:0]) && $stable(rom_bank)));

  // R7: ROM banking mode leaves RAM bank alone
  p_upper_mode0_r7: assert property (@(posedge clk) disable iff (rst)
    (hit && sel == REG_UPPER && !mode_q) |=>
      ($stable(ram_bank) && $stable(rom_bank[LO_W-1:0])));

  // R9: nothing moves without a command-window write
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !hit |=> ($stable(rom_bank) && $stable(ram_bank) && $stable(ram_en) && $stable(mode_q)));
endmodule

// File: rtl/cbc_offset.sv
module cbc_offset #(
  parameter int BANK_W   = 7,
  parameter int PAGE_LG  = 14,
  parameter int RST_BANK = 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [BANK_W-1:0]         bank_nxt,
  output logic [BANK_W+PAGE_LG-1:0] offset
);
  localparam logic [BANK_W-1:0] RST_VAL = BANK_W'(RST_BANK);

  // Registered from the next-state bank so it moves with the bank register
  always_ff @(posedge clk) begin
    if (rst) offset <= {RST_VAL, {PAGE_LG{1'b0}}};
    else     offset <= {bank_nxt, {PAGE_LG{1'b0}}};
  end
endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
  import cbc_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int ROM_BANK_W  = 7,
  parameter int RAM_BANK_W  = 2,
  parameter int ROM_PAGE_LG = 14,
  parameter int RAM_PAGE_LG = 13
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              wr_en,
  input  logic [ADDR_W-1:0]                 wr_addr,
  input  logic [DATA_W-1:0]                 wr_data,
  output logic [ROM_BANK_W-1:0]             rom_bank,
  output logic [RAM_BANK_W-1:0]             ram_bank,
  output logic                              ram_enable,
  output logic [ROM_BANK_W+ROM_PAGE_LG-1:0] rom_offset,
  output logic [RAM_BANK_W+RAM_PAGE_LG-1:0] ram_offset
);
  logic                  hit;
  cbc_reg_e              sel;
  logic [ROM_BANK_W-1:0] rom_nxt;
  logic [RAM_BANK_W-1:0] ram_nxt;

  cbc_decode #(.ADDR_W(ADDR_W)) u_decode (
    .wr_en (wr_en),
    .addr  (wr_addr),
    .hit   (hit),
    .sel   (sel)
  );

  cbc_regs #(
    .DATA_W     (DATA_W),
    .ROM_BANK_W (ROM_BANK_W),
    .RAM_BANK_W (RAM_BANK_W)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .hit      (hit),
    .sel      (sel),
    .data     (wr_data),
    .rom_bank (rom_bank),
    .ram_bank (ram_bank),
    .ram_en   (ram_enable),
    .rom_nxt  (rom_nxt),
    .ram_nxt  (ram_nxt)
  );

  cbc_offset #(.BANK_W(ROM_BANK_W), .PAGE_LG(ROM_PAGE_LG), .RST_BANK(1)) u_rom_off (
    .clk      (clk),
    .rst      (rst),
    .bank_nxt (rom_nxt),
    .offset   (rom_offset)
  );

  cbc_offset #(.BANK_W(RAM_BANK_W), .PAGE_LG(RAM_PAGE_LG), .RST_BANK(0)) u_ram_off (
    .clk      (clk),
    .rst      (rst),
    .bank_nxt (ram_nxt),
    .offset   (ram_offset)
  );

  // R8: offsets agree with the bank registers after every edge
  p_rom_offset_r8: assert property (@(posedge clk) disable iff (rst)
    rom_offset == {rom_bank, {ROM_PAGE_LG{1'b0}}});
  p_ram_offset_r8: assert property (@(posedge clk) disable iff (rst)
    ram_offset == {ram_bank, {RAM_PAGE_LG{1'b0}}});
endmodule

// File: tb/test_cart_bank_ctrl.sv
module test_cart_bank_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [6:0]  rom_bank;
  logic [1:0]  ram_bank;
  logic        ram_enable;
  logic [20:0] rom_offset;
  logic [14:0] ram_offset;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  cart_bank_ctrl i_cart_bank_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rom_bank(rom_bank), .ram_bank(ram_bank), .ram_enable(ram_enable),
    .rom_offset(rom_offset), .ram_offset(ram_offset)
  );

  // {addr, data, expected rom_bank, expected ram_bank, expected ram_enable}
  localparam int NVEC = 17;
  localparam logic [33:0] VEC [NVEC] = '{
    {16'h0000, 8'h0A, 7'h01, 2'd0, 1'b1},
    {16'h1FFF, 8'h1A, 7'h01, 2'd0, 1'b1},
    {16'h0123, 8'h0B, 7'h01, 2'd0, 1'b0},
    {16'h2000, 8'h05, 7'h05, 2'd0, 1'b0},
    {16'h3FFF, 8'hE3, 7'h03, 2'd0, 1'b0},
    {16'h2100, 8'h00, 7'h01, 2'd0, 1'b0},
    {16'h4000, 8'h02, 7'h41, 2'd0, 1'b0},
    {16'h2000, 8'h20, 7'h41, 2'd0, 1'b0},
    {16'h2000, 8'h1F, 7'h5F, 2'd0, 1'b0},
    {16'h6000, 8'h01, 7'h5F, 2'd0, 1'b0},
    {16'h5FFF, 8'h03, 7'h5F, 2'd3, 1'b0},
    {16'h7000, 8'hFE, 7'h5F, 2'd3, 1'b0},
    {16'h4000, 8'h01, 7'h3F, 2'd3, 1'b0},
    {16'h8000, 8'h00, 7'h3F, 2'd3, 1'b0},
    {16'hA000, 8'h0A, 7'h3F, 2'd3, 1'b0},
    {16'h6000, 8'h03, 7'h3F, 2'd3, 1'b0},
    {16'h4000, 8'hFC, 7'h3F, 2'd0, 1'b0}
  };

  function automatic string vec_tag(int i);
    case (i)
      0, 1, 2:  return "R2";
      3, 4, 8:  return "R3";
      5, 7:     return "R4";
      6, 12:    return "R7";
      9, 11, 15: return "R5";
      10, 16:   return "R6";
      default:  return "R9";
    endcase
  endfunction

  task automatic check(string req, logic [6:0] e_rom, logic [1:0] e_ram, logic e_en);
    logic [20:0] e_roff;
    logic [14:0] e_aoff;
    e_roff = 21'(e_rom) * 21'h4000;
    e_aoff = 15'(e_ram) * 15'h2000;
    checks++;
    if (rom_bank !== e_rom || ram_bank !== e_ram || ram_enable !== e_en ||
        rom_offset !== e_roff || ram_offset !== e_aoff) begin
      fails++;
      $display("FAIL %s/R8: rom=%h ram=%h en=%b roff=%h aoff=%h expected rom=%h ram=%h en=%b roff=%h aoff=%h",
               req, rom_bank, ram_bank, ram_enable, rom_offset, ram_offset,
               e_rom, e_ram, e_en, e_roff, e_aoff);
    end
  endtask

  task automatic do_write(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    wr_addr = a;
    wr_data = d;
    wr_en   = 1'b1;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 7'h01, 2'd0, 1'b0);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      do_write(VEC[i][33:18], VEC[i][17:10]);
      check(vec_tag(i), VEC[i][9:3], VEC[i][2:1], VEC[i][0]);
    end

    // R9: command-window address and data present, strobe low
    @(negedge clk);
    wr_addr = 16'h2000;
    wr_data = 8'h07;
    wr_en   = 1'b0;
    @(negedge clk);
    check("R9", 7'h3F, 2'd0, 1'b0);

    // R1: reset collides with a RAM-enable write
    rst     = 1'b1;
    wr_addr = 16'h0000;
    wr_data = 8'h0A;
    wr_en   = 1'b1;
    @(negedge clk);
    rst   = 1'b0;
    wr_en = 1'b0;
    check("R1", 7'h01, 2'd0, 1'b0);

    // R5: reset returned mode to ROM banking
    do_write(16'h4000, 8'h03);
    check("R5", 7'h61, 2'd0, 1'b0);

    // R4: zero low field keeps value 1 with upper bits retained
    do_write(16'h3000, 8'hE0);
    check("R4", 7'h61, 2'd0, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule